// File: doc/BRIEF.md
# Base-Delta Line Compressor

This block tries to shrink one 32-byte cache line into a base-plus-deltas image. The line is split into equal elements whose width equals the base width. Element 0 is the explicit base. Every element is then encoded as a narrow signed delta, either from that base or from an implicit base of zero. A mask records which base each element used. All elements are checked in parallel, and the line compresses only if every element fits. The base width and the delta width are parameters. The defaults are a 4-byte base and 1-byte deltas, which give eight elements.

A caller presents the line with `in_valid` for one cycle. On the next clock edge the block registers a success flag, the packed image and its size in bytes. It then holds them until the next request.

A two-state result machine drives `out_valid`. The two states are RES_EMPTY (nothing held yet, entered at reset) and RES_HELD (a result is held). It has two transitions: RES_EMPTY to RES_HELD on `in_valid`, and RES_HELD to RES_HELD on every cycle, which reloads the result whenever `in_valid` is high.

Top module: `bdi_compressor`

## Requirements
(Values below are for the defaults: 4-byte elements, 1-byte deltas.)
- R1: While reset is asserted, and after it until the first request, `out_valid`, `out_ok`, `out_size` and `out_image` are all zero.
- R2: A line sampled with `in_valid` at a rising edge produces its result on the outputs right after that edge, with `out_valid` high. The outputs then stay unchanged on every cycle with `in_valid` low, whatever `in_line` does.
- R3: Element i occupies line bytes 4i..4i+3, little-endian. On success, image bytes 0..3 hold element 0, which is the explicit base.
- R4: The explicit base is tried first. If element minus base lies in [-128, 127], its delta is the low byte of that difference and its mask bit is 0.
- R5: Otherwise, if the element itself, read as signed, lies in [-128, 127], its delta is its low byte and its mask bit is 1.
- R6: The delta of element i sits at image byte 4+i. The mask sits at image byte 12, with bit i belonging to element i.
- R7: If any element fits neither base, `out_ok` is 0, `out_image` is all zero and `out_size` is 32.
- R8: On success `out_ok` is 1 and `out_size` is 13 (4 base bytes, 8 delta bytes, 1 mask byte).
- R9: Both range limits are inclusive: +127 and -128 fit, +128 and -129 do not, for either base.
- R10: The difference from the explicit base is taken modulo 2^32, so a base of 0xFFFFFFFF and an element of 0x00000001 give a delta of +2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Line present; sample this cycle |
| in_line | input | 256 | Uncompressed line, byte 0 in bits 7:0 |
| out_valid | output | 1 | A result is held |
| out_ok | output | 1 | Line compressed |
| out_image | output | 104 | Packed image: base, deltas, mask |
| out_size | output | 6 | Image size in bytes, or 32 on failure |

## Verification
Every result is due one rising edge after the request that carries it. The bench therefore drives `in_valid` and `in_line` at a falling edge, releases them at the next falling edge, and samples the outputs there, half a cycle after the capturing edge. The hold behaviour is checked by changing `in_line` with `in_valid` low for several cycles and comparing the outputs, sampled at later falling edges, with the previous result. The reset state is sampled at falling edges while reset is held.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

    localparam int LINE_BYTES = 32;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int SIZE_W     = $clog2(LINE_BYTES + 1);

    typedef enum logic {
        RES_EMPTY = 1'b0,
        RES_HELD  = 1'b1
    } res_state_t;

    function automatic int elem_count(input int base_bytes);
        return LINE_BYTES / base_bytes;
    endfunction

    function automatic int mask_bytes(input int base_bytes);
        return (elem_count(base_bytes) + 7) / 8;
    endfunction

    function automatic int img_bytes(input int base_bytes, input int delta_bytes);
        return base_bytes + elem_count(base_bytes) * delta_bytes + mask_bytes(base_bytes);
    endfunction

endpackage

// File: rtl/bdi_lane.sv
module bdi_lane #(
    parameter int EW = 32,
    parameter int DW = 8
) (
    input  logic [EW-1:0] elem,
    input  logic [EW-1:0] base,
    output logic [DW-1:0] delta,
    output logic          use_zero,
    output logic          fits
);

    logic [EW-1:0] diff;
    logic          fit_base;
    logic          fit_zero;

    function automatic logic narrow(input logic [EW-1:0] v);
        logic [EW-DW:0] hi;
        hi = v[EW-1:DW-1];
        return (&hi) | ~(|hi);
    endfunction

    always_comb begin
        diff     = elem - base;
        fit_base = narrow(diff);
        fit_zero = narrow(elem);
        fits     = fit_base | fit_zero;
        use_zero = ~fit_base & fit_zero;
        delta    = fit_base ? diff[DW-1:0] : elem[DW-1:0];
    end

endmodule

// File: rtl/bdi_pack.sv
module bdi_pack #(
    parameter int EW        = 32,
    parameter int DW        = 8,
    parameter int N         = 8,
    parameter int MASK_BITS = 8
) (
    input  logic [EW-1:0]                    base,
    input  logic [N*DW-1:0]                  deltas,
    input  logic [N-1:0]                     mask,
    output logic [EW+N*DW+MASK_BITS-1:0]     image
);

    logic [MASK_BITS-1:0] mask_ext;

    always_comb begin
        mask_ext          = '0;
        mask_ext[N-1:0]   = mask;
        image             = {mask_ext, deltas, base};
    end

endmodule

// File: rtl/bdi_compressor.sv
module bdi_compressor #(
    parameter int BASE_BYTES  = 4,
    parameter int DELTA_BYTES = 1
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   in_valid,
    input  logic [bdi_pkg::LINE_BITS-1:0]                          in_line,
    output logic                                                   out_valid,
    output logic                                                   out_ok,
    output logic [bdi_pkg::img_bytes(BASE_BYTES, DELTA_BYTES)*8-1:0] out_image,
    output logic [bdi_pkg::SIZE_W-1:0]                             out_size
);
    import bdi_pkg::*;

    localparam int EW        = BASE_BYTES * 8;
    localparam int DW        = DELTA_BYTES * 8;
    localparam int N         = elem_count(BASE_BYTES);
    localparam int MASK_BITS = mask_bytes(BASE_BYTES) * 8;
    localparam int IMG_BYTES = img_bytes(BASE_BYTES, DELTA_BYTES);
    localparam int IMG_BITS  = IMG_BYTES * 8;
    localparam int MASK_LSB  = EW + N * DW;

    logic [EW-1:0]   base_val;
    logic [N*DW-1:0] lane_delta;
    logic [N-1:0]    lane_zero;
    logic [N-1:0]    lane_fit;
    logic [IMG_BITS-1:0] packed_img;
    logic            all_fit;

    res_state_t state_q, state_d;

    assign base_val = in_line[EW-1:0];

    for (genvar i = 0; i < N; i++) begin : g_lane
        bdi_lane #(.EW(EW), .DW(DW)) u_lane (
            .elem     (in_line[i*EW +: EW]),
            .base     (base_val),
            .delta    (lane_delta[i*DW +: DW]),
            .use_zero (lane_zero[i]),
            .fits     (lane_fit[i])
        );
    end

    bdi_pack #(.EW(EW), .DW(DW), .N(N), .MASK_BITS(MASK_BITS)) u_pack (
        .base   (base_val),
        .deltas (lane_delta),
        .mask   (lane_zero),
        .image  (packed_img)
    );

    assign all_fit = &lane_fit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RES_EMPTY: if (in_valid) state_d = RES_HELD;
            RES_HELD:  state_d = RES_HELD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RES_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_ok    <= 1'b0;
            out_image <= '0;
            out_size  <= '0;
        end else if (in_valid) begin
            out_ok    <= all_fit;
            out_image <= all_fit ? packed_img : '0;
            out_size  <= all_fit ? SIZE_W'(IMG_BYTES) : SIZE_W'(LINE_BYTES);
        end
    end

    assign out_valid = (state_q == RES_HELD);

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ok && out_image == '0 && out_size == '0)); // R1
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid) |=> ($stable(out_image) && $stable(out_ok) && $stable(out_size))); // R2
    AST_BASE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!out_ok || out_image[EW-1:0] == $past(in_line[EW-1:0]))); // R3
    AST_ELEM0_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ok) |-> (out_image[EW +: DW] == '0 && !out_image[MASK_LSB])); // R4
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ok) |-> (out_image == '0 && out_size == SIZE_W'(LINE_BYTES))); // R7
    AST_OK_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ok) |-> (out_size == SIZE_W'(IMG_BYTES))); // R8

endmodule

// File: tb/bdi_compressor_bench.sv
module bdi_compressor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] in_line = '0;
    logic         out_valid;
    logic         out_ok;
    logic [103:0] out_image;
    logic [5:0]   out_size;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bdi_compressor u_bdi_compressor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_line(in_line),
        .out_valid(out_valid), .out_ok(out_ok), .out_image(out_image), .out_size(out_size)
    );

    // line = {e7,...,e0}; expected success flag and mask byte worked out by hand
    localparam logic [255:0] T_LINE [NV] = '{
        {32'hC04039F8, 32'hC04039F0, 32'hC04039E8, 32'hC04039E0, 32'hC04039D8, 32'hC04039D0, 32'hC04039C8, 32'hC04039C0},
        {32'h09A40178, 32'h00000005, 32'h09A40100, 32'hFFFFFFF0, 32'h09A4017F, 32'h0000000B, 32'h00000000, 32'h09A40178},
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00001000, 32'h0},
        {32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h0FFFFF80, 32'h1000007F, 32'h10000000},
        {32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000080, 32'h10000000},
        {32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h10000000, 32'h0FFFFF7F, 32'h10000000},
        {32'h50000000, 32'h50000000, 32'h50000000, 32'h50000000, 32'h50000000, 32'hFFFFFF80, 32'h0000007F, 32'h50000000},
        {32'h50000000, 32'h50000000, 32'h50000000, 32'h50000000, 32'h50000000, 32'h50000000, 32'h00000080, 32'h50000000},
        {32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFF},
        {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0},
        {32'hFF, 32'hFF, 32'hFF, 32'hFF, 32'hFF, 32'hFF, 32'hFF, 32'hFF}
    };
    localparam bit T_OK [NV] = '{1, 1, 0, 1, 0, 0, 1, 0, 1, 1, 1};
    localparam logic [7:0] T_MASK [NV] = '{8'h00, 8'h56, 8'h00, 8'h00, 8'h00, 8'h00, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00};

    task automatic chk(input bit cond, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [103:0] expect_img(input logic [255:0] ln, input bit ok, input logic [7:0] m);
        logic [103:0] r;
        logic [31:0] b;
        r = '0;
        if (ok) begin
            b = ln[31:0];
            r[31:0] = b;
            for (int i = 0; i < 8; i++) begin
                logic [31:0] e;
                logic [31:0] d;
                e = ln[i*32 +: 32];
                d = m[i] ? e : (e - b);
                r[32 + i*8 +: 8] = d[7:0];
            end
            r[103:96] = m;
        end
        return r;
    endfunction

    task automatic send(input logic [255:0] ln);
        @(negedge clk);
        in_line  = ln;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [103:0] held_img;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 0 && out_ok == 0, "R1 valid/ok in reset", {out_valid, out_ok}, 0);
        chk(out_image == '0 && out_size == 0, "R1 image/size in reset", out_image, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 0 && out_image == '0, "R1 idle after reset", out_image, 0);

        for (int v = 0; v < NV; v++) begin
            logic [103:0] ei;
            send(T_LINE[v]);
            ei = expect_img(T_LINE[v], T_OK[v], T_MASK[v]);
            chk(out_valid == 1, "R2 result one edge later", out_valid, 1);
            chk(out_ok == T_OK[v], "R7 success flag", out_ok, T_OK[v]);
            chk(out_image == ei, "R6 packed image", out_image, ei);
            chk(out_size == (T_OK[v] ? 6'd13 : 6'd32), "R8 size", out_size, T_OK[v] ? 13 : 32);
            if (T_OK[v]) chk(out_image[31:0] == T_LINE[v][31:0], "R3 base copy", out_image[31:0], T_LINE[v][31:0]);
            case (v)
                0: chk(out_image[103:96] == 8'h00 && out_image[39:32] == 8'h00 && out_image[95:88] == 8'h38,
                       "R4 explicit base deltas", out_image, ei);
                1: chk(out_image[103:96] == 8'h56 && out_image[71:64] == 8'hF0 && out_image[79:72] == 8'h88,
                       "R5 zero base mix", out_image, ei);
                3: chk(out_ok && out_image[47:40] == 8'h7F && out_image[55:48] == 8'h80,
                       "R9 explicit +127/-128 fit", out_image, ei);
                4: chk(!out_ok, "R9 explicit +128 rejected", out_ok, 0);
                5: chk(!out_ok, "R9 explicit -129 rejected", out_ok, 0);
                6: chk(out_ok && out_image[103:96] == 8'h06, "R9 zero base +127/-128 fit", out_image, ei);
                7: chk(!out_ok && out_size == 6'd32, "R9 zero base +128 rejected", out_size, 32);
                8: chk(out_ok && out_image[47:40] == 8'h02 && out_image[103:96] == 8'h00,
                       "R10 modulo difference", out_image, ei);
                default: ;
            endcase
        end

        // R2: hold while in_valid low
        held_img = out_image;
        @(negedge clk);
        in_line = T_LINE[2];
        repeat (3) @(negedge clk);
        chk(out_image == held_img && out_ok == 1 && out_size == 6'd13, "R2 hold with in_valid low", out_image, held_img);

        // R7 then a back-to-back success restores
        send(T_LINE[4]);
        chk(out_image == '0 && !out_ok, "R7 failure clears image", out_image, 0);
        send(T_LINE[0]);
        chk(out_image == expect_img(T_LINE[0], 1, 8'h00), "R6 reload after failure", out_image, expect_img(T_LINE[0], 1, 8'h00));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule